// File: doc/BRIEF.md
# Configurable Timer Time-Base Counter

This block keeps a free-running time base for a timer subsystem. A global enable starts and stops it. A mode field picks what advances it. Every selected event goes through a programmable prescaler, and each time the prescaler rolls over the counter steps by one. The prescaler ratio runs from 1 to 64.

The event sources are as follows:
- In gated mode, a fixed divide-by-8 of the system clock feeds the prescaler, but only while the filtered external input is high.
- In the three edge modes, the external input itself is the source. It counts on rising edges, on falling edges, or on both.
- A plain clock/8 mode counts continuously.
- In client mode the counter ignores all of the above. It loads a value streamed from a shared time-base bus every cycle, and it refuses loads from the write port.

A write port from the controlling sequencer can load the counter directly. A write also restarts the divide-by-8 phase. A new prescaler ratio is taken up only at an increment boundary, so a ratio change never shortens or stretches the period that is already running. A registered host-side copy of the counter is provided for reads.

Top module: `timebase_counter`

## Requirements
- R1: While reset is asserted, `count_o` and `host_count_o` are both zero.
- R2: `pre_sel` = p gives a ratio of p+1. The counter advances once per p+1 source events.
- R3: In mode 4 (clock/8), with the enable high, one source event occurs every 8 clocks. After restarting with ratio p, the counter reaches 1 exactly 8(p+1) clocks after the first enabled edge.
- R4: In mode 0 (gated), divide-by-8 events reach the prescaler only while `ext_in` is high. While `ext_in` is low, the counter holds.
- R5: Mode 1 counts rising edges of `ext_in`, mode 2 counts falling edges, and mode 3 counts both.
- R6: While `gbl_en` is low, the divide-by-8 stage and the prescaler are held cleared, and the counter does not advance.
- R7: A change of `pre_sel` takes effect only after the next increment. The period already in progress completes with the old ratio.
- R8: An accepted write loads `wr_data` into the counter on the next edge and restarts the divide-by-8 phase from zero.
- R9: When a write and an increment fall on the same edge, the written value is loaded and the increment is lost.
- R10: In mode 5 (client), the counter loads `bus_val` on every edge, and writes have no effect.
- R11: The 24-bit counter wraps from all-ones to zero when it increments.
- R12: `host_count_o` equals the value `count_o` held one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gbl_en | input | 1 | Global time-base enable |
| mode_sel | input | 3 | Clock source mode (0 gated, 1 rise, 2 fall, 3 both, 4 clock/8, 5 client) |
| pre_sel | input | 6 | Prescaler ratio minus one |
| ext_in | input | 1 | Filtered external clock or gate input |
| bus_val | input | 24 | Time-base value imported from the shared bus |
| wr_en | input | 1 | Write-port load strobe |
| wr_data | input | 24 | Write-port load value |
| count_o | output | 24 | Counter value |
| host_count_o | output | 24 | Registered host-readable copy of the counter |

## Verification
The bench uses the default build: a 24-bit counter, a 6-bit prescale field and a 3-bit divide-by-8 phase. With a 6-bit prescale field, all 64 ratios can be swept in clock/8 mode. Each ratio is checked on both sides of the second increment. The write port preloads the counter near all-ones, so the wrap is reached within a few clocks. The small divider phase also makes it practical to line up a write exactly on an increment edge, and to shift the phase by a write in mid-period.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [2:0] {
    MODE_GATED  = 3'd0,
    MODE_RISE   = 3'd1,
    MODE_FALL   = 3'd2,
    MODE_BOTH   = 3'd3,
    MODE_CLK8   = 3'd4,
    MODE_CLIENT = 3'd5
  } tb_mode_e;
endpackage

// File: rtl/tbc_div8.sv
module tbc_div8 #(
  parameter int DIV_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick_o
);
  logic [DIV_W-1:0] ph_q, ph_d;
  logic             ph_en;

  always_comb begin
    ph_en = 1'b1;
    if (!run || restart) ph_d = '0;
    else                 ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign tick_o = run && (ph_q == {DIV_W{1'b1}});
endmodule

// File: rtl/tbc_src_sel.sv
module tbc_src_sel
  import tbc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tb_mode_e mode,
  input  logic     run,
  input  logic     ext_in,
  input  logic     tick8,
  output logic     src_o
);
  logic ext_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_in;
  end

  assign rise = ext_in && !ext_q;
  assign fall = !ext_in && ext_q;

  always_comb begin
    unique case (mode)
      MODE_GATED:  src_o = tick8 && ext_in;
      MODE_RISE:   src_o = rise;
      MODE_FALL:   src_o = fall;
      MODE_BOTH:   src_o = rise || fall;
      MODE_CLK8:   src_o = tick8;
      default:     src_o = 1'b0;
    endcase
    src_o = src_o && run;
  end
endmodule

// File: rtl/tbc_prescale.sv
module tbc_prescale #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src,
  input  logic [PRE_W-1:0] ratio_in,
  output logic             inc_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] ratio_q, ratio_d;
  logic             upd_en;
  logic             hit;

  assign hit = src && (cnt_q == ratio_q);

  always_comb begin
    upd_en  = 1'b0;
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (!run) begin
      upd_en  = 1'b1;
      cnt_d   = '0;
      ratio_d = ratio_in;
    end else if (src) begin
      upd_en = 1'b1;
      if (hit) begin
        cnt_d   = '0;
        ratio_d = ratio_in;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign inc_o = run && hit;
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
  import tbc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 6,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gbl_en,
  input  logic [2:0]       mode_sel,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic             ext_in,
  input  logic [CNT_W-1:0] bus_val,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] host_count_o
);
  logic       rst_meta_q, rst_sync_n;
  tb_mode_e   mode;
  logic       client;
  logic       wr_acc;
  logic       tick8, src, inc;
  logic [CNT_W-1:0] cnt_q, cnt_d, host_q;
  logic             cnt_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign mode   = tb_mode_e'(mode_sel);
  assign client = (mode == MODE_CLIENT);
  assign wr_acc = wr_en && !client;

  tbc_div8 #(.DIV_W(DIV_W)) u_div8 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (gbl_en),
    .restart (wr_acc),
    .tick_o  (tick8)
  );

  tbc_src_sel u_src (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode   (mode),
    .run    (gbl_en),
    .ext_in (ext_in),
    .tick8  (tick8),
    .src_o  (src)
  );

  tbc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (gbl_en),
    .src      (src),
    .ratio_in (pre_sel),
    .inc_o    (inc)
  );

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (client)      cnt_d = bus_val;
    else if (wr_acc) cnt_d = wr_data;
    else if (inc)    cnt_d = cnt_q + 1'b1;
    else             cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      host_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      host_q <= cnt_q;
    end
  end

  assign count_o      = cnt_q;
  assign host_count_o = host_q;
endmodule

// File: rtl/timebase_counter_chk.sv
module timebase_counter_chk
  import tbc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gbl_en,
  input logic [2:0]       mode_sel,
  input logic             ext_in,
  input logic [CNT_W-1:0] bus_val,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] host_count_o
);
  logic is_client;
  assign is_client = (mode_sel == MODE_CLIENT);

  assert_client_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_client |=> (count_o == $past(bus_val)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_client) |=> (count_o == $past(wr_data)));

  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbl_en && !wr_en && !is_client) |=> $stable(count_o));

  assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_GATED && !ext_in && !wr_en) |=> $stable(count_o));

  assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_client && !wr_en) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

  assert_host_copy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (host_count_o == $past(count_o)));
endmodule

bind timebase_counter timebase_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .gbl_en       (gbl_en),
  .mode_sel     (mode_sel),
  .ext_in       (ext_in),
  .bus_val      (bus_val),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .count_o      (count_o),
  .host_count_o (host_count_o)
);

// File: tb/timebase_counter_tb.sv
module timebase_counter_tb;
  localparam int CW = 24;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          gbl_en;
  logic [2:0]    mode_sel;
  logic [PW-1:0] pre_sel;
  logic          ext_in;
  logic [CW-1:0] bus_val;
  logic          wr_en;
  logic [CW-1:0] wr_data;
  logic [CW-1:0] count_o;
  logic [CW-1:0] host_count_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  timebase_counter u_dut (
    .clk(clk), .rst_n(rst_n), .gbl_en(gbl_en), .mode_sel(mode_sel),
    .pre_sel(pre_sel), .ext_in(ext_in), .bus_val(bus_val), .wr_en(wr_en),
    .wr_data(wr_data), .count_o(count_o), .host_count_o(host_count_o)
  );

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clear divider and prescaler with enable low, preload counter, then enable
  task automatic restart(input logic [2:0] m, input logic [PW-1:0] p, input logic [CW-1:0] v);
    mode_sel = m; pre_sel = p; gbl_en = 1'b0; ext_in = 1'b0;
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; gbl_en = 1'b1;
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_in = 1'b1; step(2);
      ext_in = 1'b0; step(2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] prev;
    rst_n = 1'b0; gbl_en = 1'b0; mode_sel = 3'd4; pre_sel = '0; ext_in = 1'b0;
    bus_val = '0; wr_en = 1'b0; wr_data = '0;
    step(3);
    check("R1 count", count_o, '0);
    check("R1 host", host_count_o, '0);
    rst_n = 1'b1;
    step(3);

    // R2 / R3: sweep every prescale ratio in clock/8 mode
    for (int p = 0; p < 64; p++) begin
      restart(3'd4, PW'(p), '0);
      step(16 * (p + 1) - 1);
      check($sformatf("R2 R3 p=%0d before", p), count_o, 24'd1);
      step(1);
      check($sformatf("R2 R3 p=%0d edge", p), count_o, 24'd2);
    end

    // R4: gated mode
    restart(3'd0, '0, '0);
    step(40);
    check("R4 gate low", count_o, '0);
    ext_in = 1'b1;
    step(40);
    check("R4 gate high", count_o, 24'd5);

    // R5: edge modes, ratio 1 and 2
    for (int p = 0; p < 2; p++) begin
      restart(3'd1, PW'(p), '0); pulses(6); step(2);
      check($sformatf("R5 rise p=%0d", p), count_o, CW'(6 / (p + 1)));
      restart(3'd2, PW'(p), '0); pulses(6); step(2);
      check($sformatf("R5 fall p=%0d", p), count_o, CW'(6 / (p + 1)));
      restart(3'd3, PW'(p), '0); pulses(6); step(2);
      check($sformatf("R5 both p=%0d", p), count_o, CW'(12 / (p + 1)));
    end

    // R6: enable low holds everything
    restart(3'd4, '0, 24'h55);
    gbl_en = 1'b0;
    step(100);
    check("R6 hold", count_o, 24'h55);

    // R7: ratio change applies only after the next increment
    restart(3'd4, 6'd3, '0);
    step(16);
    pre_sel = '0;
    step(15);
    check("R7 old ratio", count_o, '0);
    step(1);
    check("R7 boundary", count_o, 24'd1);
    step(8);
    check("R7 new ratio", count_o, 24'd2);

    // R8: write loads and restarts the divide-by-8 phase
    restart(3'd4, '0, '0);
    step(5);
    wr_en = 1'b1; wr_data = 24'h100;
    step(1);
    wr_en = 1'b0;
    step(7);
    check("R8 phase restart", count_o, 24'h100);
    step(1);
    check("R8 first tick", count_o, 24'h101);

    // R9: write on the increment edge wins
    restart(3'd4, '0, '0);
    step(7);
    wr_en = 1'b1; wr_data = 24'h40;
    step(1);
    wr_en = 1'b0;
    check("R9 write wins", count_o, 24'h40);
    step(8);
    check("R9 after", count_o, 24'h41);

    // R11: wrap
    restart(3'd4, '0, 24'hFFFFFF);
    step(7);
    check("R11 top", count_o, 24'hFFFFFF);
    step(1);
    check("R11 wrap", count_o, '0);

    // R10 / R12: client mode follows bus, writes rejected
    mode_sel = 3'd5; gbl_en = 1'b1;
    step(2);
    prev = count_o;
    for (int i = 0; i < 8; i++) begin
      bus_val = CW'(32'h0A0B01 * (i + 3));
      wr_en = 1'b1; wr_data = ~bus_val;
      step(1);
      check($sformatf("R10 follow %0d", i), count_o, bus_val);
      check($sformatf("R12 host %0d", i), host_count_o, prev);
      prev = count_o;
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule